// File: doc/BRIEF.md
# Dual-Mode PWM Period Timer

This block is one PWM timer channel. A counter of `CNT_W` bits (16 by default) runs in one of three waveforms, chosen by a mode field. Sawtooth-up counts from 0 to the period value and wraps. Sawtooth-down counts from the period value to 0 and reloads. Triangle counts up to the period value and back down. One period register sets the turning point for every mode. The PWM cycle it gives is period+1 clocks in the sawtooth modes and 2×period clocks in triangle mode.

Each of the `N_CMP` compare channels has two registers. Software writes a buffer register, and the channel copies it into an active register at a cycle boundary, so a duty change never tears a PWM cycle. In the sawtooth modes the copy is made at the wrap (or underflow) point. In triangle mode it is made at both the crest and the trough. The compare pins follow the usual edge-aligned and centre-aligned PWM rules.

A protect bit makes the channel ignore period writes, so a running waveform cannot have its frequency changed by accident. Writes to the compare buffers and to the control word are still accepted. Everything is programmed through a write-only port with an address, a data word and a strobe.

Top module: `pwm_period_timer`

## Requirements
- R1: After reset the counter reads 0, every strobe and compare pin is low, and the period register holds all ones. With the default period, a first sawtooth-up run reports its wrap strobe on the 65536th counting cycle, with the counter at 0xFFFF.
- R2: In sawtooth-up (mode field 2'b00, and also the spare code 2'b11), the counter steps by one and goes from the period value to 0. The wrap strobe is high in the cycle the counter holds the period value, so the wrap strobes are period+1 cycles apart.
- R3: In sawtooth-down (mode 2'b01), the counter steps down and reloads the period value after 0. The wrap strobe is high in the cycle the counter holds 0, so the wrap strobes are period+1 cycles apart.
- R4: In triangle mode (mode 2'b10), the counter rises to the period value and falls to 0, and its direction turns on the clock after each end point. The crest strobe is high at the period value, the trough strobe is high at 0, and crests are 2×period cycles apart.
- R5: While the protect bit (control bit 2) is 1, writes to the period register (address 1) leave the period unchanged. Compare-buffer writes still take effect. After the bit is cleared, period writes land again.
- R6: In the sawtooth modes, a value written to a compare buffer (address 2 for pin 0, address 3 for pin 1) is copied to the active compare only at the wrap or underflow point. The cycle already running keeps the old duty.
- R7: In triangle mode the buffer is copied to the active compare both at the crest and at the trough.
- R8: In the sawtooth modes a compare pin goes high on the clock that starts a cycle and goes low on the clock after the counter equals the active compare. When both happen at once, the rise wins. The pin is high for compare+1 cycles per period in up mode and for period−compare+1 cycles in down mode.
- R9: In triangle mode a compare pin goes high after a match while counting up and low after a match while counting down, giving 2×(period−compare) high cycles per PWM cycle.
- R10: Control word at address 0: bits 1:0 select the mode, bit 2 is protect, bit 3 is run. While run is 0 the counter holds its value and raises no strobe. A control write that changes the mode restarts the counter at 0, counting up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock; one count per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 control, 1 period, 2.. compare buffers |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| wrap_o | output | 1 | Sawtooth overflow or underflow strobe |
| crest_o | output | 1 | Triangle top strobe |
| trough_o | output | 1 | Triangle bottom strobe |
| cmp_o | output | N_CMP | Compare-match PWM pins |

## Verification
A wrong counter or direction state shows on `cnt_o` in the very next cycle, and it also moves the strobes away from the period or zero points at once. A wrong active-compare state stays hidden until the counter next passes the match value, so it may show up to one full PWM cycle later as a shifted compare-pin edge. The directed tests therefore place buffer writes before and after the match point and check the counter value at the first changed pin sample. A protect fault changes no pin until the counter next crosses the new period value, so the tests compare whole wrap-to-wrap intervals.

// File: rtl/pwm_timer_pkg.sv
// Shared types and register map for the PWM period timer.
// Assumes a write port whose address is at least wide enough for the
// control, period and compare-buffer locations.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        MODE_SAW_UP = 2'b00,
        MODE_SAW_DN = 2'b01,
        MODE_TRI    = 2'b10,
        MODE_SPARE  = 2'b11
    } pwm_mode_e;

    localparam int unsigned REG_CTRL     = 0;
    localparam int unsigned REG_PERIOD   = 1;
    localparam int unsigned REG_CMP_BASE = 2;

    localparam int unsigned CTRL_MODE_LSB = 0;
    localparam int unsigned CTRL_PROT_BIT = 2;
    localparam int unsigned CTRL_RUN_BIT  = 3;

endpackage

// File: rtl/pwm_timer_regs.sv
// Register bank of the timer channel: control word, period and the
// compare buffers. Period writes are dropped while protect is set.
// The spare mode code is stored as sawtooth-up, so later stages see
// only three modes. restart_o is a combinational pulse that is high
// in the cycle a control write changes the mode.
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned N_CMP  = 2,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    output pwm_mode_e                   mode_o,
    output logic                        run_o,
    output logic                        restart_o,
    output logic [CNT_W-1:0]            period_o,
    output logic [N_CMP-1:0][CNT_W-1:0] buf_o
);

    logic      sel_ctrl;
    logic      sel_period;
    pwm_mode_e new_mode;
    logic      prot_q;

    // Decode the addressed register and normalise the requested mode.
    always_comb begin
        sel_ctrl   = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
        sel_period = wr_en && (wr_addr == ADDR_W'(REG_PERIOD));
        if (wr_data[CTRL_MODE_LSB +: 2] == 2'b11)
            new_mode = MODE_SAW_UP;
        else
            new_mode = pwm_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
        restart_o = sel_ctrl && (new_mode != mode_o);
    end

    // Control word: mode, protect and run bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_SAW_UP;
            prot_q <= 1'b0;
            run_o  <= 1'b0;
        end else if (sel_ctrl) begin
            mode_o <= new_mode;
            prot_q <= wr_data[CTRL_PROT_BIT];
            run_o  <= wr_data[CTRL_RUN_BIT];
        end
    end

    // Period register; a write is dropped while protect is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_o <= '1;
        else if (sel_period && !prot_q)
            period_o <= wr_data;
    end

    // Compare buffers, one address each from REG_CMP_BASE upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_o <= '0;
        end else if (wr_en) begin
            for (int unsigned k = 0; k < N_CMP; k++) begin
                if (wr_addr == ADDR_W'(REG_CMP_BASE + k))
                    buf_o[k] <= wr_data;
            end
        end
    end

    // R5: a protected period write leaves the period unchanged.
    a_r5_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_period && prot_q) |=> $stable(period_o));

    // R5: an unprotected period write lands on the next clock.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_period && !prot_q) |=> (period_o == $past(wr_data)));

endmodule

// File: rtl/pwm_timer_counter.sv
// Counter and direction state of the channel, plus the wrap, crest and
// trough strobes decoded from it. The strobes are combinational; each
// marks the cycle in which the next clock turns or reloads the counter.
// A counter above the period (after the period shrinks) is treated as
// having reached it.
module pwm_timer_counter
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  pwm_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             wrap,
    output logic             crest,
    output logic             trough
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_top;
    logic at_zero;
    logic live;

    // End-point compares and the strobe decode.
    always_comb begin
        at_top  = (cnt >= period);
        at_zero = (cnt == '0);
        live    = run && !restart;
        wrap    = live && (((mode == MODE_SAW_UP) && at_top) ||
                           ((mode == MODE_SAW_DN) && at_zero));
        crest   = live && (mode == MODE_TRI) && dir_up && at_top;
        trough  = live && (mode == MODE_TRI) && at_zero;
    end

    // Counter and direction update for the three waveforms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (restart) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (run) begin
            case (mode)
                MODE_SAW_DN: begin
                    dir_up <= 1'b0;
                    cnt    <= at_zero ? period : cnt - ONE;
                end
                MODE_TRI: begin
                    if (period == '0) begin
                        cnt    <= '0;
                        dir_up <= 1'b1;
                    end else if (dir_up) begin
                        if (at_top) begin
                            cnt    <= cnt - ONE;
                            dir_up <= 1'b0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end else begin
                        if (at_zero) begin
                            cnt    <= ONE;
                            dir_up <= 1'b1;
                        end else begin
                            cnt <= cnt - ONE;
                        end
                    end
                end
                default: begin
                    dir_up <= 1'b1;
                    cnt    <= at_top ? '0 : cnt + ONE;
                end
            endcase
        end
    end

    // R2: an up-count wrap strobe is followed by a counter of zero.
    a_r2_up_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (mode == MODE_SAW_UP)) |=> (cnt == '0));

    // R3: an underflow strobe is followed by the period value.
    a_r3_dn_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (mode == MODE_SAW_DN)) |=> (cnt == $past(period)));

    // R4: after a crest the counter falls and the direction is down.
    a_r4_crest_turns: assert property (@(posedge clk) disable iff (!rst_n)
        (crest && (period != '0)) |=> (!dir_up && (cnt == $past(cnt) - ONE)));

    // R4: crest and trough never coincide for a non-zero period.
    a_r4_one_end_point: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> !(crest && trough));

    // R10: with run low and no restart the counter holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(cnt));

endmodule

// File: rtl/pwm_timer_compare.sv
// One compare channel: an active compare register loaded from its
// buffer at the mode's transfer point, and the PWM pin driven from
// matches against the counter. Assumes the strobes come from
// pwm_timer_counter in the same cycle as the counter value.
module pwm_timer_compare
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  pwm_mode_e        mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_up,
    input  logic             wrap,
    input  logic             crest,
    input  logic             trough,
    input  logic [CNT_W-1:0] buf_val,
    output logic             pin
);

    logic [CNT_W-1:0] active_q;
    logic             is_tri;
    logic             xfer;
    logic             match;

    // Transfer point and match decode.
    always_comb begin
        is_tri = (mode == MODE_TRI);
        xfer   = is_tri ? (crest || trough) : wrap;
        match  = run && (cnt == active_q);
    end

    // Active compare register: copies the buffer at a transfer point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (xfer)
            active_q <= buf_val;
    end

    // PWM pin: set and clear rules per waveform family.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (is_tri) begin
            if (match && dir_up)
                pin <= 1'b1;
            else if (match && !dir_up)
                pin <= 1'b0;
        end else begin
            if (wrap)
                pin <= 1'b1;
            else if (match)
                pin <= 1'b0;
        end
    end

    // R7: a triangle end point loads the buffered value.
    a_r7_tri_load: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tri && (crest || trough)) |=> (active_q == $past(buf_val)));

    // R8: a sawtooth cycle start drives the pin high.
    a_r8_saw_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_tri && wrap) |=> pin);

    // R9: an up-count match sets the pin in triangle mode.
    a_r9_tri_up_set: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tri && run && dir_up && (cnt == active_q)) |=> pin);

    // R9: a down-count match clears the pin in triangle mode.
    a_r9_tri_down_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tri && run && !dir_up && (cnt == active_q)) |=> !pin);

endmodule

// File: rtl/pwm_period_timer.sv
// Top of the PWM period timer channel: register bank, counter and
// N_CMP compare channels. Assumes a single clock and a write-only
// programming port; no reads are provided.
module pwm_period_timer
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned N_CMP  = 2,
    parameter int unsigned ADDR_W = $clog2(REG_CMP_BASE + N_CMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              wrap_o,
    output logic              crest_o,
    output logic              trough_o,
    output logic [N_CMP-1:0]  cmp_o
);

    pwm_mode_e                   mode;
    logic                        run;
    logic                        restart;
    logic [CNT_W-1:0]            period;
    logic [N_CMP-1:0][CNT_W-1:0] buf_vals;
    logic                        dir_up;

    pwm_timer_regs #(
        .CNT_W (CNT_W),
        .N_CMP (N_CMP),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode_o   (mode),
        .run_o    (run),
        .restart_o(restart),
        .period_o (period),
        .buf_o    (buf_vals)
    );

    pwm_timer_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .restart(restart),
        .mode   (mode),
        .period (period),
        .cnt    (cnt_o),
        .dir_up (dir_up),
        .wrap   (wrap_o),
        .crest  (crest_o),
        .trough (trough_o)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        pwm_timer_compare #(
            .CNT_W(CNT_W)
        ) u_compare (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .mode   (mode),
            .cnt    (cnt_o),
            .dir_up (dir_up),
            .wrap   (wrap_o),
            .crest  (crest_o),
            .trough (trough_o),
            .buf_val(buf_vals[g]),
            .pin    (cmp_o[g])
        );
    end

    // R1: the counter and the pins are cleared by reset.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> ((cnt_o == '0) && (cmp_o == '0)));

endmodule

// File: tb/tb_pwm_period_timer.sv
// Directed bench for pwm_period_timer. Inputs change and outputs are
// sampled on the falling clock edge.
module tb_pwm_period_timer;

    localparam int CNT_W  = 16;
    localparam int N_CMP  = 2;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [CNT_W-1:0]  cnt_o;
    logic              wrap_o;
    logic              crest_o;
    logic              trough_o;
    logic [N_CMP-1:0]  cmp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    pwm_period_timer #(
        .CNT_W (CNT_W),
        .N_CMP (N_CMP),
        .ADDR_W(ADDR_W)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cnt_o   (cnt_o),
        .wrap_o  (wrap_o),
        .crest_o (crest_o),
        .trough_o(trough_o),
        .cmp_o   (cmp_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input int a, input int d);
        wr_addr = ADDR_W'(a);
        wr_data = CNT_W'(d);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic next_wrap();
        do @(negedge clk); while (!wrap_o);
    endtask

    task automatic next_crest();
        do @(negedge clk); while (!crest_o);
    endtask

    task automatic wrap_gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!wrap_o);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 strobes", int'({wrap_o, crest_o, trough_o}), 0);
        check("R1 pins", int'(cmp_o), 0);
        repeat (5) @(negedge clk);
        check("R10 idle hold", int'(cnt_o), 0);
    endtask

    task automatic t_default_period();
        int n;
        int rec;
        wr(0, 'h8);
        n = 1;
        while (!wrap_o) begin @(negedge clk); n++; end
        check("R1 default period cycles", n, 65536);
        check("R1 cnt at wrap", int'(cnt_o), 'hFFFF);
        @(negedge clk);
        check("R2 wrap to zero", int'(cnt_o), 0);
        wr(0, 'h0);
        rec = int'(cnt_o);
        repeat (8) @(negedge clk);
        check("R10 stopped hold", int'(cnt_o), rec);
        check("R10 no strobe", int'(wrap_o), 0);
    endtask

    task automatic t_saw_up();
        int n;
        int ha;
        int hb;
        wr(1, 30);
        wr(2, 10);
        wr(3, 20);
        wr(0, 'h8);
        next_wrap();
        next_wrap();
        check("R2 cnt at wrap", int'(cnt_o), 30);
        wrap_gap(n);
        check("R2 period+1", n, 31);
        ha = 0;
        hb = 0;
        repeat (31) begin
            @(negedge clk);
            ha += int'(cmp_o[0]);
            hb += int'(cmp_o[1]);
        end
        check("R8 up duty pin0", ha, 11);
        check("R8 up duty pin1", hb, 21);
    endtask

    task automatic t_saw_buffer();
        while (cnt_o != 3) @(negedge clk);
        wr(2, 20);
        while (cmp_o[0]) @(negedge clk);
        check("R6 old compare kept", int'(cnt_o), 11);
        next_wrap();
        @(negedge clk);
        check("R8 set at cycle start", int'(cmp_o[0]), 1);
        while (cmp_o[0]) @(negedge clk);
        check("R6 new compare after wrap", int'(cnt_o), 21);
    endtask

    task automatic t_protect();
        int n;
        int ha;
        wr(0, 'hC);
        wr(1, 10);
        wr(2, 5);
        next_wrap();
        wrap_gap(n);
        check("R5 protected period kept", n, 31);
        ha = 0;
        repeat (31) begin @(negedge clk); ha += int'(cmp_o[0]); end
        check("R5 buffer write under protect", ha, 6);
        wr(0, 'h8);
        wr(1, 10);
        next_wrap();
        wrap_gap(n);
        check("R5 period write after unprotect", n, 11);
    endtask

    task automatic t_saw_down();
        int n;
        int ha;
        int hb;
        wr(1, 25);
        wr(2, 5);
        wr(3, 0);
        wr(0, 'h9);
        check("R10 restart cnt", int'(cnt_o), 0);
        check("R3 underflow strobe", int'(wrap_o), 1);
        @(negedge clk);
        check("R3 reload", int'(cnt_o), 25);
        next_wrap();
        wrap_gap(n);
        check("R3 period+1", n, 26);
        ha = 0;
        hb = 0;
        repeat (26) begin
            @(negedge clk);
            ha += int'(cmp_o[0]);
            hb += int'(cmp_o[1]);
        end
        check("R8 down duty pin0", ha, 21);
        check("R8 down duty zero compare", hb, 26);
    endtask

    task automatic t_triangle();
        int n;
        int ha;
        int hb;
        wr(1, 20);
        wr(2, 5);
        wr(3, 15);
        wr(0, 'hA);
        check("R4 trough at restart", int'(trough_o), 1);
        check("R4 no crest at zero", int'(crest_o), 0);
        next_crest();
        check("R4 crest value", int'(cnt_o), 20);
        n = 0;
        do begin @(negedge clk); n++; end while (!crest_o);
        check("R4 cycle 2*period", n, 40);
        ha = 0;
        hb = 0;
        repeat (40) begin
            @(negedge clk);
            ha += int'(cmp_o[0]);
            hb += int'(cmp_o[1]);
        end
        check("R9 tri duty pin0", ha, 30);
        check("R9 tri duty pin1", hb, 10);
        n = 0;
        do begin @(negedge clk); n++; end while (!trough_o);
        check("R4 crest to trough", n, 20);
        check("R4 trough value", int'(cnt_o), 0);
        while (cnt_o != 10) @(negedge clk);
        wr(2, 15);
        while (cmp_o[0]) @(negedge clk);
        check("R7 crest transfer", int'(cnt_o), 14);
        while (cnt_o != 12) @(negedge clk);
        wr(2, 8);
        while (!cmp_o[0]) @(negedge clk);
        check("R7 trough transfer", int'(cnt_o), 9);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_default_period();
        t_saw_up();
        t_saw_buffer();
        t_protect();
        t_saw_down();
        t_triangle();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule